// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits between a small CPU core and its 16-bit word memory port and takes care of interrupts. At each instruction boundary that the core reports, it decides whether an interrupt is due. Four sources can raise one: a fault from the instruction just finished, a non-maskable edge input, a maskable level request, and single-step tracing. When one is due, the block runs the entry sequence through the memory port. It stacks the flag word, code segment and instruction pointer. It then reads a far pointer from the 256-entry vector table held in the first kilobyte of memory. The loaded pointer becomes the new code position.

When the core reports a return-from-interrupt, the block pops the instruction pointer, the code segment and the flag word, in that order. It also models the halt state, and it holds the architectural flag word and the code segment, instruction pointer and stack pointer registers that the sequences touch. Every memory access waits for a ready handshake. A maskable request first goes through an acknowledge handshake that supplies its type byte.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the flag word is 0, the instruction pointer is 0, the stack pointer is 0 and the code segment is 0xFFFF. No memory access, acknowledge, halt or busy indication is active.
- R2: The entry sequence makes three word writes, each at the stack pointer minus 2 (byte address = {4'h0, SP}): first the unmodified flag word, then the code segment, then the instruction pointer. The instruction pointer pushed is the value after the finished instruction's length was added. After the first write, bit 8 (trace) and bit 9 (interrupt enable) of the flag word are both 0.
- R3: After the pushes, the sequence reads the new instruction pointer from byte address type×4 and the new code segment from type×4+2, both below 0x400. It loads both registers and goes back to idle.
- R4: A memory access keeps its request, direction and address unchanged until mem_rdy_i is seen high. The access is complete on that clock edge.
- R5: The maskable request is accepted at a boundary only while flag bit 9 is 1. It then holds inta_o high until type_vld_i is seen high, and uses type_i from that cycle as the type.
- R6: A rising edge on nmi_i is latched and serviced once with type 2. Holding the input high does not cause a second service.
- R7: A boundary with exc_req_i high is serviced with the type given on exc_type_i.
- R8: A boundary that finishes with flag bit 8 set, and has no other source due, is serviced with type 1.
- R9: When several sources are due at one boundary, the order is: instruction fault first, then non-maskable, then maskable, then single-step.
- R10: A boundary with iret_i (and no fault) reads the instruction pointer at SP, the code segment at SP+2 and the flag word at SP+4, and leaves SP raised by 6.
- R11: A boundary with hlt_i and no source due enters the halt state: halted_o is 1 and no memory access occurs. Only a non-maskable edge, or a maskable request with flag bit 9 set, ends it and starts an entry sequence.
- R12: The set/clear commands for bit 9 and bit 8 change the flag word only while the sequencer is idle. While a sequence is running they are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_done_i | input | 1 | Core finished an instruction this cycle |
| insn_len_i | input | 4 | Byte length of the finished instruction |
| hlt_i | input | 1 | Finished instruction was a halt |
| iret_i | input | 1 | Finished instruction was an interrupt return |
| exc_req_i | input | 1 | Finished instruction raised a fault |
| exc_type_i | input | 8 | Type of that fault |
| if_set_i | input | 1 | Set interrupt-enable flag |
| if_clr_i | input | 1 | Clear interrupt-enable flag |
| tf_set_i | input | 1 | Set trace flag |
| tf_clr_i | input | 1 | Clear trace flag |
| mreq_i | input | 1 | Maskable level request |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| inta_o | output | 1 | Acknowledge of maskable request |
| type_vld_i | input | 1 | Type byte valid during acknowledge |
| type_i | input | 8 | Type byte from the external controller |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data |
| mem_rdy_i | input | 1 | Access complete |
| busy_o | output | 1 | Entry or return sequence in progress |
| halted_o | output | 1 | Halt state |
| flags_o | output | 16 | Flag word |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 16 | Stack pointer |

## Verification
A wrong sequencer state shows up on the memory port within one access. The next address either leaves the expected stack slot or table entry, or the direction flips. A wrong vector or source choice surfaces at the first table read, as a wrong type×4 address, and then as wrong cs_o/ip_o values when the sequence ends. A stale interrupt-enable or trace flag shows up either in the very next stacked flag word or as a boundary that was serviced or skipped against expectation. This is why every source type, every acknowledge byte and several memory latencies are swept, and each stack and table access is compared.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    parameter int WORD_W  = 16;
    parameter int PADDR_W = 20;
    parameter int TYPE_W  = 8;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HALT, ST_ACK,
        ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP,
        ST_RD_IP, ST_RD_CS,
        ST_POP_IP, ST_POP_CS, ST_POP_F
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_EXC, SRC_NMI, SRC_MASK, SRC_STEP
    } irq_src_e;

    typedef struct packed {
        seq_state_e          state;
        logic [WORD_W-1:0]   flags;
        logic [WORD_W-1:0]   cs;
        logic [WORD_W-1:0]   ip;
        logic [WORD_W-1:0]   sp;
        logic [TYPE_W-1:0]   vec;
    } seq_regs_t;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } edge_regs_t;

    edge_regs_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = nmi_i;
        e_d.pend = (e_q.pend & ~clr_i) | (nmi_i & ~e_q.prev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign pend_o = e_q.pend;

    // R6
    nmi_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_i) |=> pend_o);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_seq_pkg::*;
#(
    parameter int NMI_VEC  = 2,
    parameter int STEP_VEC = 1
) (
    input  logic              boundary_i,
    input  logic              halt_i,
    input  logic              exc_req_i,
    input  logic [TYPE_W-1:0] exc_type_i,
    input  logic              nmi_pend_i,
    input  logic              mreq_i,
    input  logic              if_i,
    input  logic              tf_i,
    output logic              take_o,
    output irq_src_e          src_o,
    output logic [TYPE_W-1:0] vec_o
);
    logic ext_ok;

    always_comb begin
        ext_ok = boundary_i | halt_i;
        take_o = 1'b1;
        src_o  = SRC_EXC;
        vec_o  = exc_type_i;
        if (boundary_i && exc_req_i) begin
            src_o = SRC_EXC;
        end else if (ext_ok && nmi_pend_i) begin
            src_o = SRC_NMI;
            vec_o = TYPE_W'(NMI_VEC);
        end else if (ext_ok && mreq_i && if_i) begin
            src_o = SRC_MASK;
            vec_o = '0;
        end else if (boundary_i && tf_i) begin
            src_o = SRC_STEP;
            vec_o = TYPE_W'(STEP_VEC);
        end else begin
            take_o = 1'b0;
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [15:0] CS_AT_RESET = 16'hFFFF,
    parameter int          TF_POS      = 8,
    parameter int          IF_POS      = 9,
    parameter int          NMI_VEC     = 2,
    parameter int          STEP_VEC    = 1,
    parameter int          LEN_W       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               insn_done_i,
    input  logic [LEN_W-1:0]   insn_len_i,
    input  logic               hlt_i,
    input  logic               iret_i,
    input  logic               exc_req_i,
    input  logic [TYPE_W-1:0]  exc_type_i,
    input  logic               if_set_i,
    input  logic               if_clr_i,
    input  logic               tf_set_i,
    input  logic               tf_clr_i,
    input  logic               mreq_i,
    input  logic               nmi_i,
    output logic               inta_o,
    input  logic               type_vld_i,
    input  logic [TYPE_W-1:0]  type_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [PADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    input  logic               mem_rdy_i,
    output logic               busy_o,
    output logic               halted_o,
    output logic [WORD_W-1:0]  flags_o,
    output logic [WORD_W-1:0]  cs_o,
    output logic [WORD_W-1:0]  ip_o,
    output logic [WORD_W-1:0]  sp_o
);
    localparam int SEG_PAD = PADDR_W - WORD_W;
    localparam int TBL_PAD = PADDR_W - TYPE_W - 2;
    localparam int LEN_PAD = WORD_W - LEN_W;

    seq_regs_t q, d;

    logic              boundary, in_halt, nmi_pend, nmi_clr;
    logic              take;
    irq_src_e          src;
    logic [TYPE_W-1:0] pick_vec;
    logic [WORD_W-1:0] sp_dn, sp_up;

    assign boundary = (q.state == ST_IDLE) && insn_done_i;
    assign in_halt  = (q.state == ST_HALT);

    irq_nmi_edge i_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    irq_pick #(.NMI_VEC(NMI_VEC), .STEP_VEC(STEP_VEC)) i_pick (
        .boundary_i (boundary),
        .halt_i     (in_halt),
        .exc_req_i  (exc_req_i),
        .exc_type_i (exc_type_i),
        .nmi_pend_i (nmi_pend),
        .mreq_i     (mreq_i),
        .if_i       (q.flags[IF_POS]),
        .tf_i       (q.flags[TF_POS]),
        .take_o     (take),
        .src_o      (src),
        .vec_o      (pick_vec)
    );

    always_comb begin
        d           = q;
        nmi_clr     = 1'b0;
        inta_o      = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        sp_dn       = q.sp - WORD_W'(2);
        sp_up       = q.sp + WORD_W'(2);

        case (q.state)
            ST_IDLE: begin
                if (if_set_i) d.flags[IF_POS] = 1'b1;
                if (if_clr_i) d.flags[IF_POS] = 1'b0;
                if (tf_set_i) d.flags[TF_POS] = 1'b1;
                if (tf_clr_i) d.flags[TF_POS] = 1'b0;
                if (insn_done_i) begin
                    d.ip = q.ip + {{LEN_PAD{1'b0}}, insn_len_i};
                    if (take && src == SRC_EXC) begin
                        d.vec   = pick_vec;
                        d.state = ST_PUSH_F;
                    end else if (iret_i) begin
                        d.state = ST_POP_IP;
                    end else if (take) begin
                        d.vec   = pick_vec;
                        nmi_clr = (src == SRC_NMI);
                        d.state = (src == SRC_MASK) ? ST_ACK : ST_PUSH_F;
                    end else if (hlt_i) begin
                        d.state = ST_HALT;
                    end
                end
            end
            ST_HALT: begin
                if (take) begin
                    d.vec   = pick_vec;
                    nmi_clr = (src == SRC_NMI);
                    d.state = (src == SRC_MASK) ? ST_ACK : ST_PUSH_F;
                end
            end
            ST_ACK: begin
                inta_o = 1'b1;
                if (type_vld_i) begin
                    d.vec   = type_i;
                    d.state = ST_PUSH_F;
                end
            end
            ST_PUSH_F, ST_PUSH_CS, ST_PUSH_IP: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = {{SEG_PAD{1'b0}}, sp_dn};
                unique case (q.state)
                    ST_PUSH_F:  mem_wdata_o = q.flags;
                    ST_PUSH_CS: mem_wdata_o = q.cs;
                    default:    mem_wdata_o = q.ip;
                endcase
                if (mem_rdy_i) begin
                    d.sp = sp_dn;
                    unique case (q.state)
                        ST_PUSH_F: begin
                            d.flags[TF_POS] = 1'b0;
                            d.flags[IF_POS] = 1'b0;
                            d.state         = ST_PUSH_CS;
                        end
                        ST_PUSH_CS: d.state = ST_PUSH_IP;
                        default:    d.state = ST_RD_IP;
                    endcase
                end
            end
            ST_RD_IP, ST_RD_CS: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {{TBL_PAD{1'b0}}, q.vec, (q.state == ST_RD_CS), 1'b0};
                if (mem_rdy_i) begin
                    if (q.state == ST_RD_IP) begin
                        d.ip    = mem_rdata_i;
                        d.state = ST_RD_CS;
                    end else begin
                        d.cs    = mem_rdata_i;
                        d.state = ST_IDLE;
                    end
                end
            end
            ST_POP_IP, ST_POP_CS, ST_POP_F: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {{SEG_PAD{1'b0}}, q.sp};
                if (mem_rdy_i) begin
                    d.sp = sp_up;
                    unique case (q.state)
                        ST_POP_IP: begin d.ip    = mem_rdata_i; d.state = ST_POP_CS; end
                        ST_POP_CS: begin d.cs    = mem_rdata_i; d.state = ST_POP_F;  end
                        default:   begin d.flags = mem_rdata_i; d.state = ST_IDLE;   end
                    endcase
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs    <= CS_AT_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = (q.state != ST_IDLE) && (q.state != ST_HALT);
    assign halted_o = in_halt;
    assign flags_o  = q.flags;
    assign cs_o     = q.cs;
    assign ip_o     = q.ip;
    assign sp_o     = q.sp;

    // R4
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R2
    flags_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PUSH_F && mem_rdy_i) |=> (!flags_o[TF_POS] && !flags_o[IF_POS]));

    // R2
    push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_rdy_i) |=> (sp_o == $past(sp_o) - WORD_W'(2)));

    // R10
    pop_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_rdy_i && q.state inside {ST_POP_IP, ST_POP_CS, ST_POP_F})
        |=> (sp_o == $past(sp_o) + WORD_W'(2)));

    // R3
    table_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state inside {ST_RD_IP, ST_RD_CS}) |-> (mem_addr_o < PADDR_W'(1024) && !mem_addr_o[0] && !mem_we_o));

    // R5
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inta_o && !type_vld_i) |=> inta_o);

    // R11
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!mem_req_o && !inta_o && !busy_o));

    // R9
    fault_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && exc_req_i) |=> (q.state == ST_PUSH_F && q.vec == $past(exc_type_i)));
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TFB = 8;
    localparam int IFB = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic insn_done = 0, hlt = 0, iret = 0, exc_req = 0;
    logic [3:0] insn_len = 0;
    logic [7:0] exc_type = 0;
    logic if_set = 0, if_clr = 0, tf_set = 0, tf_clr = 0;
    logic mreq = 0, nmi = 0, type_vld = 0;
    logic [7:0] type_bus = 0;
    logic inta, mem_req, mem_we, mem_rdy = 0, busy, halted;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata = 0, flags, cs, ip, sp;

    int n_chk = 0, n_fail = 0;
    int lat = 0, mcnt = 0, acnt = 0, log_n = 0;
    logic [7:0] ack_type = 0;
    logic [15:0] stk [16];
    logic        log_we [16];
    logic [19:0] log_addr [16];
    logic [15:0] log_data [16];
    logic [15:0] m_flags, m_cs, m_ip, m_sp, s_flags, s_cs, s_ip, s_sp;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .insn_done_i(insn_done), .insn_len_i(insn_len),
        .hlt_i(hlt), .iret_i(iret), .exc_req_i(exc_req), .exc_type_i(exc_type),
        .if_set_i(if_set), .if_clr_i(if_clr), .tf_set_i(tf_set), .tf_clr_i(tf_clr),
        .mreq_i(mreq), .nmi_i(nmi), .inta_o(inta), .type_vld_i(type_vld), .type_i(type_bus),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy), .busy_o(busy), .halted_o(halted),
        .flags_o(flags), .cs_o(cs), .ip_o(ip), .sp_o(sp)
    );

    // memory: table entry t gives ip {8'h10,t} and cs {8'h20,t}; stack is a small window
    always @(negedge clk) begin
        if (mem_rdy) begin
            mem_rdy = 1'b0;
            mcnt = 0;
        end else if (mem_req) begin
            if (mcnt >= lat) begin
                mem_rdy = 1'b1;
                if (mem_addr < 20'h400)
                    mem_rdata = {(mem_addr[1] ? 8'h20 : 8'h10), mem_addr[9:2]};
                else
                    mem_rdata = stk[mem_addr[4:1]];
                if (mem_we) stk[mem_addr[4:1]] = mem_wdata;
                if (log_n < 16) begin
                    log_we[log_n] = mem_we;
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_wdata;
                    log_n++;
                end
            end else mcnt++;
        end
    end

    always @(negedge clk) begin
        if (type_vld) begin
            type_vld = 1'b0;
            acnt = 0;
        end else if (inta) begin
            if (acnt >= 2) begin
                type_vld = 1'b1;
                type_bus = ack_type;
            end else acnt++;
        end
    end

    task automatic check(input string req, input [31:0] act, input [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        while (busy) @(negedge clk);
    endtask

    task automatic step(input [3:0] len, input h, input r, input e, input [7:0] et);
        log_n = 0;
        @(negedge clk);
        insn_done = 1; insn_len = len; hlt = h; iret = r; exc_req = e; exc_type = et;
        m_ip = m_ip + 16'(len);
        @(negedge clk);
        insn_done = 0; hlt = 0; iret = 0; exc_req = 0;
        wait_done();
    endtask

    task automatic cmd(input is, input ic, input ts, input tc);
        @(negedge clk);
        if_set = is; if_clr = ic; tf_set = ts; tf_clr = tc;
        @(negedge clk);
        if_set = 0; if_clr = 0; tf_set = 0; tf_clr = 0;
        if (is) m_flags[IFB] = 1'b1;
        if (ic) m_flags[IFB] = 1'b0;
        if (ts) m_flags[TFB] = 1'b1;
        if (tc) m_flags[TFB] = 1'b0;
    endtask

    task automatic chk_acc(input string req, input int i, input logic we, input [19:0] a,
                           input logic cd, input [15:0] dat);
        check(req, {31'd0, log_we[i]}, {31'd0, we});
        check(req, {12'd0, log_addr[i]}, {12'd0, a});
        if (cd) check(req, {16'd0, log_data[i]}, {16'd0, dat});
    endtask

    task automatic chk_entry(input [7:0] t, input string req);
        check(req, log_n, 5);
        chk_acc({req, " R2 flags push"}, 0, 1, {4'h0, 16'(m_sp - 16'd2)}, 1, m_flags);
        chk_acc({req, " R2 cs push"},    1, 1, {4'h0, 16'(m_sp - 16'd4)}, 1, m_cs);
        chk_acc({req, " R2 ip push"},    2, 1, {4'h0, 16'(m_sp - 16'd6)}, 1, m_ip);
        chk_acc({req, " R3 ip read"},    3, 0, {10'd0, t, 2'b00}, 0, 16'h0);
        chk_acc({req, " R3 cs read"},    4, 0, {10'd0, t, 2'b10}, 0, 16'h0);
        s_flags = m_flags; s_cs = m_cs; s_ip = m_ip; s_sp = m_sp;
        m_sp = m_sp - 16'd6;
        m_flags[TFB] = 1'b0;
        m_flags[IFB] = 1'b0;
        m_ip = {8'h10, t};
        m_cs = {8'h20, t};
        check({req, " R3 ip"}, {16'd0, ip}, {16'd0, m_ip});
        check({req, " R3 cs"}, {16'd0, cs}, {16'd0, m_cs});
        check({req, " R2 flags"}, {16'd0, flags}, {16'd0, m_flags});
        check({req, " R2 sp"}, {16'd0, sp}, {16'd0, m_sp});
    endtask

    task automatic do_ret();
        step(4'd1, 0, 1, 0, 8'h0);
        check("R10 count", log_n, 3);
        chk_acc("R10 ip pop", 0, 0, {4'h0, 16'(s_sp - 16'd6)}, 0, 16'h0);
        chk_acc("R10 cs pop", 1, 0, {4'h0, 16'(s_sp - 16'd4)}, 0, 16'h0);
        chk_acc("R10 flags pop", 2, 0, {4'h0, 16'(s_sp - 16'd2)}, 0, 16'h0);
        m_flags = s_flags; m_cs = s_cs; m_ip = s_ip; m_sp = s_sp;
        check("R10 ip", {16'd0, ip}, {16'd0, m_ip});
        check("R10 cs", {16'd0, cs}, {16'd0, m_cs});
        check("R10 flags", {16'd0, flags}, {16'd0, m_flags});
        check("R10 sp", {16'd0, sp}, {16'd0, m_sp});
    endtask

    task automatic leave_halt();
        log_n = 0;
        for (int n = 0; n < 50 && halted; n++) @(negedge clk);
        @(negedge clk);
        wait_done();
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) stk[i] = 16'h0;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 flags", {16'd0, flags}, 32'h0);
        check("R1 ip", {16'd0, ip}, 32'h0);
        check("R1 cs", {16'd0, cs}, 32'hFFFF);
        check("R1 sp", {16'd0, sp}, 32'h0);
        check("R1 idle", {28'd0, busy, halted, mem_req, inta}, 32'h0);
        rst_n = 1'b1;
        m_flags = 16'h0; m_cs = 16'hFFFF; m_ip = 16'h0; m_sp = 16'h0;
        @(negedge clk);
        check("R1 after release", {29'd0, busy, mem_req, inta}, 32'h0);

        // R7 fault types, all 256, with varied latency (R4) and returns (R10)
        for (int t = 0; t < 256; t++) begin
            lat = t % 3;
            step(4'(t % 7 + 1), 0, 0, 1, 8'(t));
            chk_entry(8'(t), "R7");
            do_ret();
        end

        // R12 command while idle
        cmd(1, 0, 0, 0);
        check("R12 if set", {16'd0, flags}, {16'd0, m_flags});

        // R5 all acknowledge bytes
        for (int t = 0; t < 256; t++) begin
            lat = (t + 1) % 3;
            ack_type = 8'(t);
            mreq = 1;
            step(4'd2, 0, 0, 0, 8'h0);
            mreq = 0;
            chk_entry(8'(t), "R5");
            do_ret();
        end

        // R5 masked request ignored while enable flag is 0
        cmd(0, 1, 0, 0);
        mreq = 1;
        step(4'd3, 0, 0, 0, 8'h0);
        check("R5 masked no access", log_n, 0);
        check("R5 masked ip", {16'd0, ip}, {16'd0, m_ip});
        mreq = 0;
        cmd(1, 0, 0, 0);

        // R6 held nmi serviced once
        @(negedge clk); nmi = 1;
        step(4'd1, 0, 0, 0, 8'h0);
        chk_entry(8'd2, "R6");
        do_ret();
        step(4'd1, 0, 0, 0, 8'h0);
        check("R6 once", log_n, 0);
        @(negedge clk); nmi = 0;

        // R12 commands ignored during a sequence
        lat = 3;
        log_n = 0;
        @(negedge clk);
        insn_done = 1; insn_len = 4'd2; exc_req = 1; exc_type = 8'h77;
        m_ip = m_ip + 16'd2;
        @(negedge clk);
        insn_done = 0; exc_req = 0;
        while (!(mem_req && mem_addr == 20'h001DE)) @(negedge clk);
        if_set = 1; tf_set = 1;
        @(negedge clk);
        if_set = 0; tf_set = 0;
        wait_done();
        chk_entry(8'h77, "R12 busy ignored");
        do_ret();
        lat = 1;

        // R9 priority, R8 single-step
        cmd(0, 0, 1, 0);
        @(negedge clk); nmi = 1;
        @(negedge clk); nmi = 0;
        mreq = 1; ack_type = 8'h55;
        step(4'd2, 0, 0, 1, 8'h00);
        chk_entry(8'h00, "R9 fault first");
        do_ret();
        step(4'd1, 0, 0, 0, 8'h0);
        chk_entry(8'd2, "R9 nmi second");
        do_ret();
        step(4'd1, 0, 0, 0, 8'h0);
        mreq = 0;
        chk_entry(8'h55, "R9 maskable third");
        do_ret();
        step(4'd3, 0, 0, 0, 8'h0);
        chk_entry(8'd1, "R8 step");
        do_ret();
        cmd(0, 0, 0, 1);

        // R11 halt with interrupts disabled, left by nmi
        cmd(0, 1, 0, 0);
        step(4'd1, 1, 0, 0, 8'h0);
        check("R11 halted", {31'd0, halted}, 32'd1);
        mreq = 1; ack_type = 8'h21;
        repeat (8) @(negedge clk);
        check("R11 quiet", log_n, 0);
        check("R11 still halted", {31'd0, halted}, 32'd1);
        @(negedge clk); nmi = 1;
        @(negedge clk); nmi = 0;
        leave_halt();
        mreq = 0;
        check("R11 left", {31'd0, halted}, 32'd0);
        chk_entry(8'd2, "R11 nmi exit");
        do_ret();

        // R11 halt left by maskable request
        cmd(1, 0, 0, 0);
        step(4'd1, 1, 0, 0, 8'h0);
        check("R11 halted again", {31'd0, halted}, 32'd1);
        mreq = 1;
        leave_halt();
        mreq = 0;
        chk_entry(8'h21, "R11 maskable exit");
        do_ret();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule